// File: doc/BRIEF.md
# Multi-Mode Microcontroller Bus Port

This block sits between a host microcontroller bus and three 8-bit groups of device pins, called C, D and E. Groups C and D behave the same way. Every pin has its own 2-bit role field. A pin can be a plain register I/O pin. It can drive a bit of the latched host address. It can act as one lane of a non-multiplexed data bus. It can also be a direct logic input that is never driven. A per-pin bit selects a push-pull driver or an open-drain driver.

Group E picks among four output sources for each pin: the output register, the low address byte, the high address byte, or no drive. In that last role, called alternate input, three of its pins feed the bus logic:

- pin 1 replaces the host ALE that loads the address latch;
- pin 0 supplies the byte-high enable strobe;
- pin 7 supplies the power-down counter clock.

The address latch loads the host address on each falling edge of the effective ALE, as seen on the clock. It holds that value until the next falling edge. Group D either drives the low address byte or the high address byte. It drives the high byte only when the bus is both 16 bits wide and multiplexed.

Top module: `busPortTop`

## Requirements
- R1: The address latch loads `hostAddr` at the first clock edge where the effective ALE is low after being high at the previous edge. At every other edge it holds.
- R2: A group C pin with role 1 (address) drives latched address bit i with output enable high.
- R3: A group D pin with role 1 drives latched bit 8+i when `busWide` and `busMux` are both 1. Otherwise it drives latched bit i.
- R4: A pin with role 2 (data) drives lane bits of `intRdData` only while `rdStb` is 1. Group C uses bits 7:0 and group D uses bits 15:8. Its output enable is 0 otherwise.
- R5: At a clock edge with `wrStb` at 1, the pin level of each role-2 pin is loaded into its lane bit of `intWrData`. All other bits hold.
- R6: A role-0 pin drives its output register bit when its direction bit is 1. When the direction bit is 0, output enable is 0 and the pin level appears in `dataIn*` one clock later.
- R7: With the open-drain bit set, `pinOut` is 0 and output enable is 1 only when the pin would drive a 0.
- R8: A group C/D pin with role 3 is never driven. Its `logic*` output follows the pin, and that output is 0 for pins in other roles.
- R9: Group E roles are: 0 register I/O, 1 address bit i, 2 address bit 8+i, 3 alternate input (never driven).
- R10: If E pin 1 has role 3, it replaces `hostAle` for R1. If E pin 0 has role 3, `bheOut` follows it, and if E pin 7 has role 3, `apdClk` follows it. Each of these outputs is 0 when its pin is in another role.
- R11: After reset the latch, `dataIn*` and `intWrData` are zero.
- Pin i's role sits in mode bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hostAddr | input | 16 | Host address |
| hostAle | input | 1 | Host address latch enable |
| rdStb | input | 1 | Host read cycle active |
| wrStb | input | 1 | Host write cycle active |
| busWide | input | 1 | 1 = 16-bit bus |
| busMux | input | 1 | 1 = multiplexed bus |
| intRdData | input | 16 | Internal read data for the pins |
| intWrData | output | 16 | Data captured from the pins on writes |
| cfgModeC | input | 16 | Group C pin roles |
| cfgDirC | input | 8 | Group C direction, 1 = out |
| cfgOdC | input | 8 | Group C open-drain select |
| cfgOutC | input | 8 | Group C output register |
| cfgModeD | input | 16 | Group D pin roles |
| cfgDirD | input | 8 | Group D direction |
| cfgOdD | input | 8 | Group D open-drain select |
| cfgOutD | input | 8 | Group D output register |
| cfgModeE | input | 16 | Group E pin roles |
| cfgDirE | input | 8 | Group E direction |
| cfgOdE | input | 8 | Group E open-drain select |
| cfgOutE | input | 8 | Group E output register |
| pinInC | input | 8 | Group C pin levels |
| pinOutC | output | 8 | Group C pin drive value |
| pinOeC | output | 8 | Group C output enables |
| dataInC | output | 8 | Group C input register |
| logicC | output | 8 | Group C direct logic inputs |
| pinInD | input | 8 | Group D pin levels |
| pinOutD | output | 8 | Group D pin drive value |
| pinOeD | output | 8 | Group D output enables |
| dataInD | output | 8 | Group D input register |
| logicD | output | 8 | Group D direct logic inputs |
| pinInE | input | 8 | Group E pin levels |
| pinOutE | output | 8 | Group E pin drive value |
| pinOeE | output | 8 | Group E output enables |
| dataInE | output | 8 | Group E input register |
| bheOut | output | 1 | Byte-high enable from E pin 0 |
| apdClk | output | 1 | Power-down counter clock from E pin 7 |

## Verification
A wrong address latch value shows on every address-role pin in the same cycle it is loaded. A missed or extra ALE fall becomes visible on the next clock. An ALE edge taken from the wrong source corrupts the latch only when the two sources disagree, so the bench drives them apart on purpose. A bad captured register shows in `dataIn*` or `intWrData` one clock after the capture edge. Wrong drive logic is combinational and shows on `pinOe*` as soon as the inputs change. The reference model therefore compares every output on every clock.

// File: rtl/busPortPkg.sv
package busPortPkg;
  typedef enum logic [1:0] {
    CdIo    = 2'd0,
    CdAddr  = 2'd1,
    CdData  = 2'd2,
    CdLogic = 2'd3
  } cdRole_t;

  typedef enum logic [1:0] {
    EIo     = 2'd0,
    EAddrLo = 2'd1,
    EAddrHi = 2'd2,
    EAlt    = 2'd3
  } eRole_t;

  typedef struct packed {
    logic aleFall;
    logic rdDrive;
    logic wrCap;
  } portStrobe_t;
endpackage

// File: rtl/busPortCtrl.sv
module busPortCtrl
  import busPortPkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostAle,
  input  logic               rdStb,
  input  logic               wrStb,
  input  logic [2*PIN_W-1:0] cfgModeE,
  input  logic [PIN_W-1:0]   pinInE,
  output portStrobe_t        strb,
  output logic               bheOut,
  output logic               apdClk
);
  localparam int ClkPin = PIN_W - 1;

  logic aleEff;
  logic aleQ;
  logic altPin0;
  logic altPin1;
  logic altPin7;

  assign altPin0 = (eRole_t'(cfgModeE[1:0]) == EAlt);
  assign altPin1 = (eRole_t'(cfgModeE[3:2]) == EAlt);
  assign altPin7 = (eRole_t'(cfgModeE[2*ClkPin +: 2]) == EAlt);

  assign aleEff = altPin1 ? pinInE[1] : hostAle;
  assign bheOut = altPin0 & pinInE[0];
  assign apdClk = altPin7 & pinInE[ClkPin];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) aleQ <= 1'b0;
    else       aleQ <= aleEff;
  end

  assign strb.aleFall = aleQ & ~aleEff;
  assign strb.rdDrive = rdStb;
  assign strb.wrCap   = wrStb;

  // R1
  single_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.aleFall |=> !strb.aleFall);
endmodule

// File: rtl/busPortDatapath.sv
module busPortDatapath
  import busPortPkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  portStrobe_t                   strb,
  input  logic [2*PIN_W-1:0]            hostAddr,
  input  logic                          busWide,
  input  logic                          busMux,
  input  logic [2*PIN_W-1:0]            intRdData,
  output logic [2*PIN_W-1:0]            intWrData,
  input  logic [1:0][2*PIN_W-1:0]       cfgMode,
  input  logic [1:0][PIN_W-1:0]         cfgDir,
  input  logic [1:0][PIN_W-1:0]         cfgOd,
  input  logic [1:0][PIN_W-1:0]         cfgOut,
  input  logic [1:0][PIN_W-1:0]         pinIn,
  output logic [1:0][PIN_W-1:0]         pinOut,
  output logic [1:0][PIN_W-1:0]         pinOe,
  output logic [1:0][PIN_W-1:0]         dataIn,
  output logic [1:0][PIN_W-1:0]         logicOut,
  input  logic [2*PIN_W-1:0]            cfgModeE,
  input  logic [PIN_W-1:0]              cfgDirE,
  input  logic [PIN_W-1:0]              cfgOdE,
  input  logic [PIN_W-1:0]              cfgOutE,
  input  logic [PIN_W-1:0]              pinInE,
  output logic [PIN_W-1:0]              pinOutE,
  output logic [PIN_W-1:0]              pinOeE,
  output logic [PIN_W-1:0]              dataInE
);
  localparam int ADDR_W = 2 * PIN_W;

  logic [ADDR_W-1:0] latAddr;
  logic              highHalf;
  logic [1:0][PIN_W-1:0] dataMask;
  logic [1:0][PIN_W-1:0] logicMask;
  logic [PIN_W-1:0]      altMaskE;

  assign highHalf = busWide & busMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latAddr <= '0;
    else if (strb.aleFall) latAddr <= hostAddr;
  end

  for (genvar p = 0; p < 2; p++) begin : g_cd
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      cdRole_t role;
      logic    src;
      logic    drv;
      logic    addrBit;
      logic    dinQ;
      logic    wrQ;

      assign role = cdRole_t'(cfgMode[p][2*i +: 2]);

      if (p == 0) begin : g_lo
        assign addrBit = latAddr[i];
      end else begin : g_hi
        assign addrBit = highHalf ? latAddr[PIN_W+i] : latAddr[i];
      end

      always_comb begin
        unique case (role)
          CdIo:    begin src = cfgOut[p][i];            drv = cfgDir[p][i]; end
          CdAddr:  begin src = addrBit;                 drv = 1'b1;         end
          CdData:  begin src = intRdData[p*PIN_W + i];  drv = strb.rdDrive; end
          default: begin src = 1'b0;                    drv = 1'b0;         end
        endcase
      end

      assign pinOut[p][i]    = cfgOd[p][i] ? 1'b0 : src;
      assign pinOe[p][i]     = cfgOd[p][i] ? (drv & ~src) : drv;
      assign dataMask[p][i]  = (role == CdData);
      assign logicMask[p][i] = (role == CdLogic);
      assign logicOut[p][i]  = (role == CdLogic) & pinIn[p][i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               dinQ <= 1'b0;
        else if (role == CdIo && !cfgDir[p][i])  dinQ <= pinIn[p][i];
      end
      assign dataIn[p][i] = dinQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               wrQ <= 1'b0;
        else if (strb.wrCap && role == CdData)   wrQ <= pinIn[p][i];
      end
      assign intWrData[p*PIN_W + i] = wrQ;
    end
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_e
    eRole_t role;
    logic   src;
    logic   drv;
    logic   dinQ;

    assign role = eRole_t'(cfgModeE[2*i +: 2]);

    always_comb begin
      unique case (role)
        EIo:     begin src = cfgOutE[i];         drv = cfgDirE[i]; end
        EAddrLo: begin src = latAddr[i];         drv = 1'b1;       end
        EAddrHi: begin src = latAddr[PIN_W+i];   drv = 1'b1;       end
        default: begin src = 1'b0;               drv = 1'b0;       end
      endcase
    end

    assign pinOutE[i]  = cfgOdE[i] ? 1'b0 : src;
    assign pinOeE[i]   = cfgOdE[i] ? (drv & ~src) : drv;
    assign altMaskE[i] = (role == EAlt);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       dinQ <= 1'b0;
      else if (role == EIo && !cfgDirE[i]) dinQ <= pinInE[i];
    end
    assign dataInE[i] = dinQ;
  end

  // R1
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.aleFall |=> $stable(latAddr));

  // R4
  data_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdDrive |-> ((pinOe[0] & dataMask[0]) == '0 && (pinOe[1] & dataMask[1]) == '0));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCap |=> $stable(intWrData));

  // R7
  od_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut[0] & pinOe[0] & cfgOd[0]) == '0) && ((pinOutE & pinOeE & cfgOdE) == '0));

  // R8
  logic_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe[0] & logicMask[0]) == '0) && ((pinOe[1] & logicMask[1]) == '0));

  // R10
  alt_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOeE & altMaskE) == '0);
endmodule

// File: rtl/busPortTop.sv
module busPortTop
  import busPortPkg::*;
#(
  parameter int PIN_W = 8,
  localparam int ADDR_W = 2 * PIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostAle,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              busWide,
  input  logic              busMux,
  input  logic [ADDR_W-1:0] intRdData,
  output logic [ADDR_W-1:0] intWrData,
  input  logic [ADDR_W-1:0] cfgModeC,
  input  logic [PIN_W-1:0]  cfgDirC,
  input  logic [PIN_W-1:0]  cfgOdC,
  input  logic [PIN_W-1:0]  cfgOutC,
  input  logic [ADDR_W-1:0] cfgModeD,
  input  logic [PIN_W-1:0]  cfgDirD,
  input  logic [PIN_W-1:0]  cfgOdD,
  input  logic [PIN_W-1:0]  cfgOutD,
  input  logic [ADDR_W-1:0] cfgModeE,
  input  logic [PIN_W-1:0]  cfgDirE,
  input  logic [PIN_W-1:0]  cfgOdE,
  input  logic [PIN_W-1:0]  cfgOutE,
  input  logic [PIN_W-1:0]  pinInC,
  output logic [PIN_W-1:0]  pinOutC,
  output logic [PIN_W-1:0]  pinOeC,
  output logic [PIN_W-1:0]  dataInC,
  output logic [PIN_W-1:0]  logicC,
  input  logic [PIN_W-1:0]  pinInD,
  output logic [PIN_W-1:0]  pinOutD,
  output logic [PIN_W-1:0]  pinOeD,
  output logic [PIN_W-1:0]  dataInD,
  output logic [PIN_W-1:0]  logicD,
  input  logic [PIN_W-1:0]  pinInE,
  output logic [PIN_W-1:0]  pinOutE,
  output logic [PIN_W-1:0]  pinOeE,
  output logic [PIN_W-1:0]  dataInE,
  output logic              bheOut,
  output logic              apdClk
);
  portStrobe_t               strb;
  logic [1:0][PIN_W-1:0]     pinOutCD;
  logic [1:0][PIN_W-1:0]     pinOeCD;
  logic [1:0][PIN_W-1:0]     dataInCD;
  logic [1:0][PIN_W-1:0]     logicCD;

  busPortCtrl #(.PIN_W(PIN_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostAle (hostAle),
    .rdStb   (rdStb),
    .wrStb   (wrStb),
    .cfgModeE(cfgModeE),
    .pinInE  (pinInE),
    .strb    (strb),
    .bheOut  (bheOut),
    .apdClk  (apdClk)
  );

  busPortDatapath #(.PIN_W(PIN_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hostAddr (hostAddr),
    .busWide  (busWide),
    .busMux   (busMux),
    .intRdData(intRdData),
    .intWrData(intWrData),
    .cfgMode  ({cfgModeD, cfgModeC}),
    .cfgDir   ({cfgDirD, cfgDirC}),
    .cfgOd    ({cfgOdD, cfgOdC}),
    .cfgOut   ({cfgOutD, cfgOutC}),
    .pinIn    ({pinInD, pinInC}),
    .pinOut   (pinOutCD),
    .pinOe    (pinOeCD),
    .dataIn   (dataInCD),
    .logicOut (logicCD),
    .cfgModeE (cfgModeE),
    .cfgDirE  (cfgDirE),
    .cfgOdE   (cfgOdE),
    .cfgOutE  (cfgOutE),
    .pinInE   (pinInE),
    .pinOutE  (pinOutE),
    .pinOeE   (pinOeE),
    .dataInE  (dataInE)
  );

  assign pinOutC = pinOutCD[0];
  assign pinOutD = pinOutCD[1];
  assign pinOeC  = pinOeCD[0];
  assign pinOeD  = pinOeCD[1];
  assign dataInC = dataInCD[0];
  assign dataInD = dataInCD[1];
  assign logicC  = logicCD[0];
  assign logicD  = logicCD[1];
endmodule

// File: tb/test_busPortTop.sv
module test_busPortTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] hostAddr = '0, intRdData = '0, cfgModeC = '0, cfgModeD = '0, cfgModeE = '0;
  logic hostAle = 0, rdStb = 0, wrStb = 0, busWide = 0, busMux = 0;
  logic [7:0] cfgDirC = '0, cfgOdC = '0, cfgOutC = '0, cfgDirD = '0, cfgOdD = '0, cfgOutD = '0;
  logic [7:0] cfgDirE = '0, cfgOdE = '0, cfgOutE = '0, pinInC = '0, pinInD = '0, pinInE = '0;
  logic [15:0] intWrData;
  logic [7:0] pinOutC, pinOeC, dataInC, logicC, pinOutD, pinOeD, dataInD, logicD;
  logic [7:0] pinOutE, pinOeE, dataInE;
  logic bheOut, apdClk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] mAddr = '0, mWr = '0;
  logic mAleQ = 0;
  logic [7:0] mDinC = '0, mDinD = '0, mDinE = '0;

  always #5 clk = ~clk;

  busPortTop i_busPortTop (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int roleOf(input logic [15:0] m, input int i);
    return int'(m[2*i +: 2]);
  endfunction

  // Expected drive for one pin given source value, drive request, open-drain bit.
  function automatic logic [1:0] pad(input logic s, input logic d, input logic od);
    if (od) return {1'b0, d && !s};
    return {s, d};
  endfunction

  task automatic compareAll();
    logic [7:0] eOutC, eOeC, eOutD, eOeD, eOutE, eOeE, eLogC, eLogD;
    logic [1:0] r;
    logic s, d;
    logic aleE;
    for (int i = 0; i < 8; i++) begin
      case (roleOf(cfgModeC, i))
        0: begin s = cfgOutC[i]; d = cfgDirC[i]; end
        1: begin s = mAddr[i]; d = 1; end
        2: begin s = intRdData[i]; d = rdStb; end
        default: begin s = 0; d = 0; end
      endcase
      r = pad(s, d, cfgOdC[i]); eOutC[i] = r[1]; eOeC[i] = r[0];
      eLogC[i] = (roleOf(cfgModeC, i) == 3) && pinInC[i];
      case (roleOf(cfgModeD, i))
        0: begin s = cfgOutD[i]; d = cfgDirD[i]; end
        1: begin s = (busWide && busMux) ? mAddr[8+i] : mAddr[i]; d = 1; end
        2: begin s = intRdData[8+i]; d = rdStb; end
        default: begin s = 0; d = 0; end
      endcase
      r = pad(s, d, cfgOdD[i]); eOutD[i] = r[1]; eOeD[i] = r[0];
      eLogD[i] = (roleOf(cfgModeD, i) == 3) && pinInD[i];
      case (roleOf(cfgModeE, i))
        0: begin s = cfgOutE[i]; d = cfgDirE[i]; end
        1: begin s = mAddr[i]; d = 1; end
        2: begin s = mAddr[8+i]; d = 1; end
        default: begin s = 0; d = 0; end
      endcase
      r = pad(s, d, cfgOdE[i]); eOutE[i] = r[1]; eOeE[i] = r[0];
    end
    aleE = 0;
    chk("pinOutC R2 R4 R6 R7", {8'h0, pinOutC}, {8'h0, eOutC});
    chk("pinOeC R2 R4 R6 R7", {8'h0, pinOeC}, {8'h0, eOeC});
    chk("pinOutD R3 R4", {8'h0, pinOutD}, {8'h0, eOutD});
    chk("pinOeD R3 R4", {8'h0, pinOeD}, {8'h0, eOeD});
    chk("pinOutE R9", {8'h0, pinOutE}, {8'h0, eOutE});
    chk("pinOeE R9", {8'h0, pinOeE}, {8'h0, eOeE});
    chk("logic R8", {logicD, logicC}, {eLogD, eLogC});
    chk("dataIn R6", {dataInD, dataInC}, {mDinD, mDinC});
    chk("dataInE R6", {8'h0, dataInE}, {8'h0, mDinE});
    chk("intWrData R5", intWrData, mWr);
    chk("bhe R10", {15'h0, bheOut}, {15'h0, (roleOf(cfgModeE, 0) == 3) && pinInE[0]});
    chk("apdClk R10", {15'h0, apdClk}, {15'h0, (roleOf(cfgModeE, 7) == 3) && pinInE[7]});
    if (aleE) chk("unused", 16'h0, 16'h0);
  endtask

  task automatic modelEdge();
    logic aleEff;
    aleEff = (roleOf(cfgModeE, 1) == 3) ? pinInE[1] : hostAle;
    if (mAleQ && !aleEff) mAddr = hostAddr;
    mAleQ = aleEff;
    for (int i = 0; i < 8; i++) begin
      if (roleOf(cfgModeC, i) == 0 && !cfgDirC[i]) mDinC[i] = pinInC[i];
      if (roleOf(cfgModeD, i) == 0 && !cfgDirD[i]) mDinD[i] = pinInD[i];
      if (roleOf(cfgModeE, i) == 0 && !cfgDirE[i]) mDinE[i] = pinInE[i];
      if (wrStb && roleOf(cfgModeC, i) == 2) mWr[i] = pinInC[i];
      if (wrStb && roleOf(cfgModeD, i) == 2) mWr[8+i] = pinInD[i];
    end
  endtask

  // Inputs are set after a falling edge; compare, then take one rising edge.
  task automatic step();
    #1;
    compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R11 reset state
    chk("R11 intWrData", intWrData, 16'h0);
    chk("R11 dataIn", {dataInD, dataInC}, 16'h0);
    rstN = 1;
    @(negedge clk);
    step();

    // R6 register I/O
    cfgDirC = 8'hF0; cfgOutC = 8'hA5; pinInC = 8'h3C;
    step();
    #1 chk("R6 oe", {8'h0, pinOeC}, 16'h00F0);
    chk("R6 din", {8'h0, dataInC}, 16'h000C);

    // R7 open drain
    cfgDirC = 8'hFF; cfgOdC = 8'hFF; cfgOutC = 8'h0F;
    step();
    #1 chk("R7 oe", {8'h0, pinOeC}, 16'h00F0);
    chk("R7 out", {8'h0, pinOutC}, 16'h0000);
    cfgOdC = '0;

    // R1 R2 address latch
    cfgModeC = 16'h5555;
    hostAddr = 16'h1234; hostAle = 1; step();
    hostAle = 0; step();
    hostAddr = 16'hFFFF; step();
    #1 chk("R2 addr", {8'h0, pinOutC}, 16'h0034);
    chk("R1 hold", {8'h0, pinOutC}, 16'h0034);
    hostAddr = 16'hABCD; hostAle = 1; step();
    hostAle = 0; step();
    hostAddr = 16'h0000; step();
    #1 chk("R1 new", {8'h0, pinOutC}, 16'h00CD);

    // R3 high or low byte on D
    cfgModeD = 16'h5555; busWide = 1; busMux = 1; step();
    #1 chk("R3 high", {8'h0, pinOutD}, 16'h00AB);
    busWide = 0; step();
    #1 chk("R3 low", {8'h0, pinOutD}, 16'h00CD);
    busWide = 1; busMux = 0; step();

    // R4 data lanes
    cfgModeC = 16'hAAAA; cfgModeD = 16'hAAAA; intRdData = 16'h5AC3;
    step();
    #1 chk("R4 idle", {pinOeD, pinOeC}, 16'h0000);
    rdStb = 1; step();
    #1 chk("R4 read", {pinOutD, pinOutC}, 16'h5AC3);
    rdStb = 0;

    // R5 write capture
    pinInC = 8'h77; pinInD = 8'h88; wrStb = 1; step();
    wrStb = 0; pinInC = 8'hFF; step();
    #1 chk("R5 cap", intWrData, 16'h8877);
    cfgModeC = 16'h00AA; cfgDirC = 8'h00; wrStb = 1; step();
    wrStb = 0; step();
    #1 chk("R5 partial", intWrData, 16'h887F);

    // R8 logic inputs
    cfgModeC = 16'hFFFF; pinInC = 8'h96; step();
    #1 chk("R8 logic", {8'h0, logicC}, 16'h0096);
    chk("R8 oe", {8'h0, pinOeC}, 16'h0000);

    // R9 group E sources
    cfgModeE = 16'h0A50; cfgDirE = 8'hC3; cfgOutE = 8'h81; step();
    #1 chk("R9 oe", {8'h0, pinOeE}, 16'h00FF);
    chk("R9 out", {8'h0, pinOutE}, 16'h00AD);
    cfgDirE = 8'h00; pinInE = 8'h5A; step(); step();
    cfgOdE = 8'hFF; step();

    // R10 alternate inputs
    cfgOdE = '0; cfgModeC = 16'h5555;
    cfgModeE = 16'hC00F; hostAddr = 16'h5A5A; pinInE = 8'h02; step();
    pinInE = 8'h81; step();
    #1 chk("R10 bhe", {15'h0, bheOut}, 16'h1);
    chk("R10 apd", {15'h0, apdClk}, 16'h1);
    chk("R10 ale", {8'h0, pinOutC}, 16'h005A);
    chk("R10 float", {8'h0, pinOeE & 8'h83}, 16'h0000);
    hostAddr = 16'h1111; hostAle = 1; pinInE = 8'h00; step();
    hostAle = 0; step(); step();
    #1 chk("R10 host ignored", {8'h0, pinOutC}, 16'h005A);
    cfgModeE = 16'h0000; step();
    #1 chk("R10 bhe off", {15'h0, bheOut}, 16'h0);

    for (int k = 0; k < 4; k++) begin
      pinInC = 8'(k * 37); rdStb = k[0]; step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule